// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block watches a wide vector of general-purpose input pins and turns selected transitions or levels on them into interrupt requests. The pins are split into groups of up to eight. Every pin has its own 4-bit trigger-mode field, which selects active-low level, active-high level, falling edge, rising edge or both edges. When a pin's condition is met, the pin's pending flag is latched. The flag stays latched until software clears it by writing a one to it.

Software reaches three register banks through a simple word-addressed read/write port. The banks hold the trigger-mode fields, the per-pin masks and the pending flags, with one 32-bit word for each group in every bank. The controller drives one combined interrupt line. That line is high while at least one pending flag has a clear mask bit. The pins are expected to arrive already synchronised to the block clock.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every configuration, mask and pending register reads zero, and `irq_o` is low. The stored previous pin sample also resets to zero.
- R2: Mode code 0 (level low) and mode code 1 (level high) set the pin's pending flag on every cycle in which the pin sits at the active level. A clear written while that level persists therefore does not take effect.
- R3: Mode code 2 (falling) sets pending only when the pin is 0 and its sample from the previous clock was 1. Mode code 3 (rising) sets pending only when the pin is 1 and its previous sample was 0. A held level after the edge sets nothing more.
- R4: Mode code 4 (both edges) sets pending whenever the pin differs from its previous sample.
- R5: Mode codes 5 through 15 never set pending, whatever the pin does.
- R6: Pin p of a group is controlled by configuration bits [4p+3:4p] of that group's word. It uses bit p of the group's mask and pending words. Mask and pending bits 8 to 31 read zero.
- R7: The configuration bank starts at byte address 0x700, the mask bank at 0x900 and the pending bank at 0xA00. Group g (0 to 20) sits at bank base + 4g.
- R8: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. A trigger in the same cycle wins over the clear.
- R9: A mask bit of 1 keeps that pin out of `irq_o`, and a mask bit of 0 lets it through. Masking never stops pending from being latched.
- R10: `irq_o` is high exactly when some pending bit is set and its mask bit is 0. It follows the registers combinationally.
- R11: Addresses outside the three banks return zero on reads and ignore writes. This covers unaligned addresses and group indices above 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 168 | Synchronised pin levels; pin p of group g at bit 8g+p |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The checker examines every pin on every cycle. It confirms that each latched trigger matches the pin level its mode code allows, that undefined codes stay silent, and that a trigger always lands in pending even when the pin is masked. It also confirms that a pending flag only drops after a clear strobe for that pin, that writes to unmapped addresses leave configuration and mask untouched, and that `irq_o` never rises with no pending flag set. The directed scenarios are needed to show the exact field and bit positions, the bank addresses, the one-shot behaviour of edge modes against a held level, and the cycle on which the combined line follows a mask change.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  typedef enum logic [3:0] {
    TRIG_LVL_LO = 4'd0,
    TRIG_LVL_HI = 4'd1,
    TRIG_FALL   = 4'd2,
    TRIG_RISE   = 4'd3,
    TRIG_BOTH   = 4'd4
  } trig_mode_e;

  // Trigger decision for one pin given its mode, current and previous sample.
  function automatic logic trig_hit(logic [3:0] mode, logic cur, logic prev);
    logic hit;
    case (mode)
      TRIG_LVL_LO: hit = !cur;
      TRIG_LVL_HI: hit = cur;
      TRIG_FALL:   hit = prev & !cur;
      TRIG_RISE:   hit = !prev & cur;
      TRIG_BOTH:   hit = prev ^ cur;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

  // True when addr is an aligned word inside a bank of n words starting at base.
  function automatic logic in_bank(int unsigned addr, int unsigned base, int unsigned n);
    return (addr >= base) && (addr < base + 4 * n) && (addr[1:0] == 2'b00);
  endfunction

  // Word index of addr within the bank starting at base.
  function automatic int unsigned slot_of(int unsigned addr, int unsigned base);
    return (addr - base) >> 2;
  endfunction

endpackage

// File: rtl/pinirq_decode.sv
module pinirq_decode
  import pinirq_pkg::*;
#(
  parameter int NUM_GROUPS = 21,
  parameter int ADDR_W     = 12,
  parameter int CFG_BASE   = 'h700,
  parameter int MSK_BASE   = 'h900,
  parameter int PND_BASE   = 'hA00,
  localparam int GIDX_W    = $clog2(NUM_GROUPS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cfg_sel_o,
  output logic              msk_sel_o,
  output logic              pnd_sel_o,
  output logic              hit_o,
  output logic [GIDX_W-1:0] grp_o
);
  int unsigned a;

  always_comb begin
    a         = 32'(addr_i);
    cfg_sel_o = in_bank(a, CFG_BASE, NUM_GROUPS);
    msk_sel_o = in_bank(a, MSK_BASE, NUM_GROUPS);
    pnd_sel_o = in_bank(a, PND_BASE, NUM_GROUPS);
    hit_o     = cfg_sel_o | msk_sel_o | pnd_sel_o;
    grp_o     = '0;
    if (cfg_sel_o)      grp_o = GIDX_W'(slot_of(a, CFG_BASE));
    else if (msk_sel_o) grp_o = GIDX_W'(slot_of(a, MSK_BASE));
    else if (pnd_sel_o) grp_o = GIDX_W'(slot_of(a, PND_BASE));
  end
endmodule

// File: rtl/pinirq_group.sv
module pinirq_group
  import pinirq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 32,
  localparam int CFG_W = PINS * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_i,
  input  logic              cfg_we_i,
  input  logic              msk_we_i,
  input  logic              pnd_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [PINS-1:0]   msk_o,
  output logic [PINS-1:0]   pnd_o,
  output logic [PINS-1:0]   set_o,
  output logic [PINS-1:0]   clr_o
);
  logic [PINS-1:0]  prev_q;
  logic [CFG_W-1:0] cfg_q;
  logic [PINS-1:0]  msk_q;
  logic [PINS-1:0]  pnd_q;

  // Per-pin trigger detection.
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign set_o[p] = trig_hit(cfg_q[p*4 +: 4], pin_i[p], prev_q[p]);
  end

  // Write-one-to-clear strobes for this group.
  assign clr_o = pnd_we_i ? wdata_i[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cfg_q  <= '0;
      msk_q  <= '0;
      pnd_q  <= '0;
    end else begin
      prev_q <= pin_i;
      if (cfg_we_i) cfg_q <= wdata_i[CFG_W-1:0];
      if (msk_we_i) msk_q <= wdata_i[PINS-1:0];
      pnd_q <= (pnd_q & ~clr_o) | set_o;
    end
  end

  assign cfg_o = cfg_q;
  assign msk_o = msk_q;
  assign pnd_o = pnd_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NUM_GROUPS     = 21,
  parameter int PINS_PER_GROUP = 8,
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32,
  parameter int CFG_BASE       = 'h700,
  parameter int MSK_BASE       = 'h900,
  parameter int PND_BASE       = 'hA00,
  localparam int NPINS         = NUM_GROUPS * PINS_PER_GROUP,
  localparam int CFG_W         = PINS_PER_GROUP * 4,
  localparam int GIDX_W        = $clog2(NUM_GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic              cfg_sel, msk_sel, pnd_sel, dec_hit;
  logic [GIDX_W-1:0] grp;

  logic [NUM_GROUPS*CFG_W-1:0] cfg_flat;
  logic [NPINS-1:0]            msk_flat;
  logic [NPINS-1:0]            pnd_flat;
  logic [NPINS-1:0]            set_flat;
  logic [NPINS-1:0]            clr_flat;

  pinirq_decode #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W),
    .CFG_BASE(CFG_BASE), .MSK_BASE(MSK_BASE), .PND_BASE(PND_BASE)
  ) u_decode (
    .addr_i    (bus_addr_i),
    .cfg_sel_o (cfg_sel),
    .msk_sel_o (msk_sel),
    .pnd_sel_o (pnd_sel),
    .hit_o     (dec_hit),
    .grp_o     (grp)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel_g;
    assign sel_g = bus_wr_i && (grp == GIDX_W'(g));
    pinirq_group #(.PINS(PINS_PER_GROUP), .DATA_W(DATA_W)) u_group (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pins_i[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .cfg_we_i (sel_g && cfg_sel),
      .msk_we_i (sel_g && msk_sel),
      .pnd_we_i (sel_g && pnd_sel),
      .wdata_i  (bus_wdata_i),
      .cfg_o    (cfg_flat[g*CFG_W +: CFG_W]),
      .msk_o    (msk_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .pnd_o    (pnd_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .set_o    (set_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
      .clr_o    (clr_flat[g*PINS_PER_GROUP +: PINS_PER_GROUP])
    );
  end

  // Read mux: zero-extended register contents, zero when nothing decodes.
  always_comb begin
    bus_rdata_o = '0;
    if (cfg_sel)
      bus_rdata_o[CFG_W-1:0] = cfg_flat[grp*CFG_W +: CFG_W];
    else if (msk_sel)
      bus_rdata_o[PINS_PER_GROUP-1:0] = msk_flat[grp*PINS_PER_GROUP +: PINS_PER_GROUP];
    else if (pnd_sel)
      bus_rdata_o[PINS_PER_GROUP-1:0] = pnd_flat[grp*PINS_PER_GROUP +: PINS_PER_GROUP];
  end

  assign irq_o = |(pnd_flat & ~msk_flat);
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker #(
  parameter int NPINS = 168
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPINS-1:0]   pins_i,
  input logic [NPINS*4-1:0] cfg_flat,
  input logic [NPINS-1:0]   msk_flat,
  input logic [NPINS-1:0]   pnd_flat,
  input logic [NPINS-1:0]   set_flat,
  input logic [NPINS-1:0]   clr_flat,
  input logic               dec_hit,
  input logic               bus_wr_i,
  input logic               irq_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    logic [3:0] fld;
    assign fld = cfg_flat[i*4 +: 4];

    // R5 (also R2, R3): a trigger needs a defined code and the matching pin level.
    assert_trigger_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_flat[i] |-> (fld <= 4'd4) &&
                      ((fld == 4'd4) || (pins_i[i] == ((fld == 4'd1) || (fld == 4'd3)))));

    // R9 (also R8): a trigger is always captured, masked or not.
    assert_capture_under_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_flat[i] |=> pnd_flat[i]);

    // R8: a pending flag only drops after a clear strobe for it.
    assert_clear_only_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pnd_flat[i]) |-> $past(clr_flat[i]));
  end

  // R10: the combined line needs some pending flag.
  assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|pnd_flat));

  // R11: writes to unmapped addresses leave configuration and mask alone.
  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !dec_hit) |=> ($stable(cfg_flat) && $stable(msk_flat)));
endmodule

bind pin_irq_ctrl pinirq_checker #(.NPINS(NPINS)) u_pinirq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pins_i   (pins_i),
  .cfg_flat (cfg_flat),
  .msk_flat (msk_flat),
  .pnd_flat (pnd_flat),
  .set_flat (set_flat),
  .clr_flat (clr_flat),
  .dec_hit  (dec_hit),
  .bus_wr_i (bus_wr_i),
  .irq_o    (irq_o)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  localparam int NG = 21;
  localparam int NP = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic [11:0]   addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pins_i(pins),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // Bench-side address map (R7).
  function automatic logic [11:0] cfg_a(int g); return 12'(32'h700 + 4 * g); endfunction
  function automatic logic [11:0] msk_a(int g); return 12'(32'h900 + 4 * g); endfunction
  function automatic logic [11:0] pnd_a(int g); return 12'(32'hA00 + 4 * g); endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic set_pin(int g, int p, logic v);
    pins[g*8 + p] = v;
    tick();
  endtask

  task automatic chk_rd(logic [11:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(logic exp, string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic t_reset();
    chk_irq(1'b0, "R1 reset");
    chk_rd(cfg_a(0), 32'h0, "R1 cfg g0");
    chk_rd(msk_a(20), 32'h0, "R1 mask g20");
    chk_rd(pnd_a(5), 32'h0, "R1 pend g5");
  endtask

  task automatic t_map();
    wr_reg(cfg_a(3), 32'hFEDC_BA98);
    chk_rd(cfg_a(3), 32'hFEDC_BA98, "R6 R7 cfg g3 readback");
    wr_reg(msk_a(20), 32'hFFFF_FFFF);
    chk_rd(msk_a(20), 32'h0000_00FF, "R6 mask upper bits zero");
    wr_reg(12'h754, 32'hFFFF_FFFF);
    chk_rd(12'h754, 32'h0, "R11 group 21 reads zero");
    wr_reg(12'h702, 32'hFFFF_FFFF);
    chk_rd(12'h702, 32'h0, "R11 unaligned reads zero");
    chk_rd(cfg_a(0), 32'h0, "R11 unaligned write ignored");
    wr_reg(12'h800, 32'hFFFF_FFFF);
    chk_rd(msk_a(0), 32'h0, "R11 gap write ignored");
  endtask

  task automatic t_undefined();
    for (int p = 0; p < 8; p++) set_pin(3, p, 1'b0);
    for (int p = 0; p < 8; p++) set_pin(3, p, 1'b1);
    tick();
    chk_rd(pnd_a(3), 32'h0, "R5 undefined codes silent");
    chk_irq(1'b0, "R5 no irq");
  endtask

  task automatic t_level();
    wr_reg(cfg_a(0), 32'h0000_0010);   // pin1 level high, others level low
    tick();
    chk_rd(pnd_a(0), 32'h2, "R2 level high sets");
    chk_irq(1'b1, "R10 irq from g0 pin1");
    wr_reg(pnd_a(0), 32'h2);
    chk_rd(pnd_a(0), 32'h2, "R2 R8 clear loses to held level");
    set_pin(0, 1, 1'b0);
    wr_reg(pnd_a(0), 32'h2);
    chk_rd(pnd_a(0), 32'h0, "R8 clear after level drops");
    chk_irq(1'b0, "R10 irq low after clear");
    set_pin(0, 2, 1'b0);
    set_pin(0, 2, 1'b1);
    chk_rd(pnd_a(0), 32'h4, "R2 level low latched");
    wr_reg(pnd_a(0), 32'h1);
    chk_rd(pnd_a(0), 32'h4, "R8 write zero leaves bit");
    wr_reg(pnd_a(0), 32'h4);
    chk_rd(pnd_a(0), 32'h0, "R8 write one clears");
  endtask

  task automatic t_edges();
    wr_reg(cfg_a(7), 32'hFFFF_F423);  // pin0 rise, pin1 fall, pin2 both
    tick();
    chk_rd(pnd_a(7), 32'h0, "R3 no edge no pending");
    set_pin(7, 1, 1'b0);
    chk_rd(pnd_a(7), 32'h2, "R3 falling edge");
    wr_reg(pnd_a(7), 32'h2);
    tick(); tick();
    chk_rd(pnd_a(7), 32'h0, "R3 held low is one-shot");
    set_pin(7, 0, 1'b0);
    chk_rd(pnd_a(7), 32'h0, "R3 rise mode ignores fall");
    set_pin(7, 0, 1'b1);
    chk_rd(pnd_a(7), 32'h1, "R3 rising edge");
    wr_reg(pnd_a(7), 32'h1);
    set_pin(7, 2, 1'b0);
    chk_rd(pnd_a(7), 32'h4, "R4 both edges fall");
    wr_reg(pnd_a(7), 32'h4);
    chk_rd(pnd_a(7), 32'h0, "R4 cleared");
    set_pin(7, 2, 1'b1);
    chk_rd(pnd_a(7), 32'h4, "R4 both edges rise");
    wr_reg(pnd_a(7), 32'hFF);
    set_pin(7, 1, 1'b1);
    wr_reg(pnd_a(7), 32'hFF);
  endtask

  task automatic t_mask();
    wr_reg(cfg_a(20), 32'h3FFF_FFFF);  // pin7 rising
    wr_reg(msk_a(20), 32'h0000_0080);
    set_pin(20, 7, 1'b0);
    set_pin(20, 7, 1'b1);
    chk_rd(pnd_a(20), 32'h80, "R9 masked pin still latched");
    chk_irq(1'b0, "R9 mask blocks irq");
    wr_reg(msk_a(20), 32'h0);
    chk_irq(1'b1, "R10 unmask raises irq");
    wr_reg(pnd_a(20), 32'h80);
    chk_irq(1'b0, "R10 clear drops irq");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_map();
    t_undefined();
    t_level();
    t_edges();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule